// File: doc/BRIEF.md
# Write-Through Set-Associative Data Cache

This block is the data cache between a load/store unit and a slow backing data memory. It takes one request at a time through a valid/ready port. A request is either a 32-bit word or an 8-bit byte, and either a load or a store. Load results come back on a response port. The cache holds 32 KB in four ways with 16-byte lines, which gives 512 sets. A load that hits returns its data in the cycle after it is accepted. A load that misses fetches the whole line from the backing memory, installs it, and returns the requested data in the same cycle the line arrives.

Stores never leave dirty state behind. Every store is sent to the backing memory as one word-wide write with byte strobes. A store that hits also updates the enabled bytes of the cached line. A store that misses does not allocate. The block keeps at most one memory transaction open at a time and holds its request port closed until that transaction ends.

On a miss, a set that still has an empty way fills that way first. When the set is full, the victim way is taken from the low bits of a free-running 16-bit LFSR.

Top module: `wt_dcache`

## Requirements
- R1: After reset every way of every set is invalid. `req_ready` is 1 and `resp_valid` and `mem_req` are 0, and the first load to any address is a miss.
- R2: A load that hits is answered with `resp_valid`=1 in the cycle after the cycle in which it was accepted (`req_valid`&&`req_ready`). Hit loads can be accepted back to back.
- R3: A load miss raises `mem_req` with `mem_store`=0 and a line-aligned `mem_addr` (low 4 bits zero). When `mem_ack` rises, the response carries the requested data taken from `mem_rdata`, where byte k of the line is `mem_rdata[8k+7:8k]`. Later loads to that line hit.
- R4: A word load (`req_byte`=0) returns the 4 bytes at the word-aligned address in little-endian order. A byte load (`req_byte`=1) returns the byte at `req_addr`, sign-extended from bit 7 to 32 bits.
- R5: Every store produces exactly one backing write and no response. The write has `mem_store`=1 and `mem_addr` equal to the word-aligned address. A word store uses `mem_wstrb`=4'b1111 and `mem_wdata`=`req_wdata`. A byte store uses `mem_wstrb`=1<<`req_addr[1:0]` and carries `req_wdata[7:0]` on every lane.
- R6: A store that hits changes only its enabled bytes of the cached line. A later hit load returns the new bytes and the untouched neighbouring bytes unchanged.
- R7: A store that misses does not allocate. The next load to that line is a miss and returns the stored data from the backing memory.
- R8: While a backing transaction is open, `req_ready` is 0 and `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `req_ready` returns the cycle after `mem_ack`.
- R9: A miss fills an invalid way of the set before it evicts anything. Four different tags loaded into one set all hit afterwards. A fifth tag replaces one way chosen by the low 2 bits of a nonzero 16-bit LFSR, and the data returned afterwards is always correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data (byte stores use bits 7:0) |
| resp_valid | output | 1 | Load data valid |
| resp_data | output | 32 | Load data, byte loads sign-extended |
| mem_req | output | 1 | Backing transaction open |
| mem_store | output | 1 | 1 = write, 0 = line read |
| mem_addr | output | 32 | Word address for writes, line address for reads |
| mem_wdata | output | 32 | Write data, lanes replicated for byte stores |
| mem_wstrb | output | 4 | Byte lane enables for writes |
| mem_ack | input | 1 | One-cycle completion pulse from backing memory |
| mem_rdata | input | 128 | Line data, valid with `mem_ack` on reads |

## Verification
Two things can fall in one cycle. A hit response can leave the lookup stage in the same cycle that the next request is accepted and its array read starts. A line fill can write the arrays in the same cycle that it returns the missed data. Back-to-back loads to one line provoke the first case. The bench places them right behind a miss, so that a hit load follows in the cycle after a fill completes. The scoreboard judges each response by its data against a shadow byte model and by its cycle distance from acceptance: 1 for a hit and 12 for a miss.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } dc_state_e;

endpackage

// File: rtl/dcache_way.sv
// One way of the cache: a tag array and a data array, each a simple
// dual-port memory with a registered read port so block RAM is inferred.
module dcache_way #(
  parameter int SETS       = 512,
  parameter int TAG_W      = 19,
  parameter int LINE_BYTES = 16,
  localparam int IDX_W     = $clog2(SETS),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [LINE_W-1:0]     rd_line,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_tag_en,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [LINE_BYTES-1:0] wr_ben,
  input  logic [LINE_W-1:0]     wr_line
);

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_tag_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en)     rd_tag <= tag_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (wr_ben[b]) line_mem[wr_idx][b*8 +: 8] <= wr_line[b*8 +: 8];
    end
    if (rd_en) rd_line <= line_mem[rd_idx];
  end

endmodule

// File: rtl/dcache_victim.sv
// Victim way selection: lowest invalid way first, otherwise LFSR low bits.
module dcache_victim #(
  parameter int              WAYS      = 4,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int             WAY_W     = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WAYS-1:0]  valid_set,
  output logic [WAY_W-1:0] victim
);

  logic [LFSR_W-1:0] lfsr;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= LFSR_W'(1);
    else     lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & LFSR_TAPS)};
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = lfsr[WAY_W-1:0];
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_set[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst) lfsr != '0); // R9
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (rst)
    (valid_set != '1) |-> !valid_set[victim]); // R9

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import dcache_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                WORD_W     = 32,
  parameter int                CAPACITY   = 32768,
  parameter int                WAYS       = 4,
  parameter int                LINE_BYTES = 16,
  parameter int                LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int SETS       = CAPACITY / (LINE_BYTES * WAYS),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W      = $clog2(WAYS),
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int WB_W       = $clog2(WORD_BYTES),
  localparam int WPL        = LINE_BYTES / WORD_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_store,
  input  logic                  req_byte,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  output logic                  resp_valid,
  output logic [WORD_W-1:0]     resp_data,
  output logic                  mem_req,
  output logic                  mem_store,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  output logic [WORD_BYTES-1:0] mem_wstrb,
  input  logic                  mem_ack,
  input  logic [LINE_W-1:0]     mem_rdata
);

  // lookup-stage request
  dc_state_e         state;
  logic              s1_valid, s1_store, s1_byte;
  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] s1_wdata;
  logic [WAY_W-1:0]  vic_q;
  logic [WAY_W-1:0]  victim;

  logic [WAYS-1:0]   valid_q [SETS];

  logic [IDX_W-1:0]  s1_idx, req_idx;
  logic [TAG_W-1:0]  s1_tag;
  logic [OFF_W-1:0]  s1_off;
  logic [WAYS-1:0]   set_valid;

  assign s1_idx    = s1_addr[OFF_W +: IDX_W];
  assign s1_tag    = s1_addr[ADDR_W-1 -: TAG_W];
  assign s1_off    = s1_addr[OFF_W-1:0];
  assign req_idx   = req_addr[OFF_W +: IDX_W];
  assign set_valid = valid_q[s1_idx];

  logic [TAG_W-1:0]      way_tag  [WAYS];
  logic [LINE_W-1:0]     way_line [WAYS];
  logic [LINE_BYTES-1:0] way_ben  [WAYS];
  logic [WAYS-1:0]       way_tag_we;
  logic [WAYS-1:0]       hit_vec;
  logic [WAY_W-1:0]      hit_way;
  logic                  hit;

  logic                  accept, needs_mem, hit_load, store_hit, fill_done;
  logic [LINE_BYTES-1:0] st_ben;
  logic [WORD_W-1:0]     st_word;
  logic [LINE_W-1:0]     wr_line;

  // pick a word or a sign-extended byte out of a line
  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] line,
                                             input logic [OFF_W-1:0]  off,
                                             input logic              is_byte);
    logic [WORD_W-1:0] w;
    logic [7:0]        b;
    w = line[off[OFF_W-1:WB_W]*WORD_W +: WORD_W];
    b = line[off*8 +: 8];
    return is_byte ? {{(WORD_W-8){b[7]}}, b} : w;
  endfunction

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |hit_vec;

  assign needs_mem = s1_valid && (s1_store || !hit);
  assign req_ready = (state == ST_IDLE) && !needs_mem;
  assign accept    = req_valid && req_ready;
  assign hit_load  = s1_valid && !s1_store && hit;
  assign store_hit = (state == ST_IDLE) && s1_valid && s1_store && hit;
  assign fill_done = (state == ST_FILL) && mem_ack;

  // store lane enables within the line
  always_comb begin
    st_ben = '0;
    if (s1_byte) begin
      st_ben[s1_off] = 1'b1;
    end else begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        st_ben[{s1_off[OFF_W-1:WB_W], WB_W'(b)}] = 1'b1;
      end
    end
  end

  assign st_word = s1_byte ? {WORD_BYTES{s1_wdata[7:0]}} : s1_wdata;
  assign wr_line = fill_done ? mem_rdata : {WPL{st_word}};

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w]    = set_valid[w] && (way_tag[w] == s1_tag);
      assign way_tag_we[w] = fill_done && (vic_q == WAY_W'(w));
      assign way_ben[w]    = (store_hit && hit_way == WAY_W'(w)) ? st_ben :
                             way_tag_we[w] ? {LINE_BYTES{1'b1}} : '0;

      dcache_way #(
        .SETS       (SETS),
        .TAG_W      (TAG_W),
        .LINE_BYTES (LINE_BYTES)
      ) u_way (
        .clk       (clk),
        .rd_en     (accept),
        .rd_idx    (req_idx),
        .rd_tag    (way_tag[w]),
        .rd_line   (way_line[w]),
        .wr_idx    (s1_idx),
        .wr_tag_en (way_tag_we[w]),
        .wr_tag    (s1_tag),
        .wr_ben    (way_ben[w]),
        .wr_line   (wr_line)
      );
    end
  endgenerate

  dcache_victim #(
    .WAYS      (WAYS),
    .LFSR_W    (LFSR_W),
    .LFSR_TAPS (LFSR_TAPS)
  ) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_set (set_valid),
    .victim    (victim)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      s1_valid <= 1'b0;
      vic_q    <= '0;
    end else begin
      s1_valid <= accept;
      unique case (state)
        ST_IDLE: begin
          if (s1_valid && s1_store) begin
            state <= ST_WRITE;
          end else if (s1_valid && !hit) begin
            state <= ST_FILL;
            vic_q <= victim;
          end
        end
        ST_FILL, ST_WRITE: if (mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_store <= req_store;
      s1_byte  <= req_byte;
      s1_addr  <= req_addr;
      s1_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (fill_done) begin
      valid_q[s1_idx][vic_q] <= 1'b1;
    end
  end

  assign resp_valid = hit_load || fill_done;
  assign resp_data  = fill_done ? pick(mem_rdata, s1_off, s1_byte)
                                : pick(way_line[hit_way], s1_off, s1_byte);

  assign mem_req   = (state != ST_IDLE);
  assign mem_store = (state == ST_WRITE);
  assign mem_addr  = (state == ST_WRITE) ? {s1_addr[ADDR_W-1:WB_W], {WB_W{1'b0}}}
                                         : {s1_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata = st_word;
  assign mem_wstrb = s1_byte ? (WORD_BYTES'(1) << s1_addr[WB_W-1:0]) : {WORD_BYTES{1'b1}};

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $onehot0(hit_vec)); // R2
  AST_NO_STORE_RESP: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_store) |-> !resp_valid); // R5
  AST_CLOSED_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R8
  AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_store && mem_ack) |-> resp_valid); // R3

endmodule

// File: tb/wt_dcache_tb_top.sv
module wt_dcache_tb_top;

  localparam int LAT      = 10;
  localparam int HIT_LAT  = 1;
  localparam int MISS_LAT = LAT + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_store = 1'b0, req_byte = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         req_ready, resp_valid, mem_req, mem_store;
  logic [31:0]  resp_data, mem_addr, mem_wdata;
  logic [3:0]   mem_wstrb;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #10 clk = ~clk;

  wt_dcache dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .mem_req(mem_req), .mem_store(mem_store), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, r8_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // backing store and shadow model
  logic [7:0] bmem [int unsigned];
  logic [7:0] rmem [int unsigned];

  function automatic logic [7:0] seed_byte(input int unsigned a);
    return 8'((a * 37) ^ (a >> 8) ^ 32'h95);
  endfunction
  function automatic logic [7:0] mem_rd(input int unsigned a);
    return bmem.exists(a) ? bmem[a] : seed_byte(a);
  endfunction
  function automatic logic [7:0] ref_rd(input int unsigned a);
    return rmem.exists(a) ? rmem[a] : seed_byte(a);
  endfunction

  typedef struct { logic [31:0] data; int lat; int acc; string rq; } ld_t;
  typedef struct { logic [31:0] addr; logic [3:0] strb; logic [31:0] data; string rq; } wr_t;
  ld_t ldq[$];
  wr_t wrq[$];

  // driver
  task automatic issue(input bit st, input bit by, input logic [31:0] a,
                       input logic [31:0] wd, input int lat, input string rq);
    ld_t e;
    wr_t w;
    logic [7:0] b;
    int unsigned wa;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_byte = by; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    wa = {a[31:2], 2'b00};
    if (!st) begin
      if (by) begin
        b = ref_rd(a);
        e.data = {{24{b[7]}}, b};
      end else begin
        e.data = {ref_rd(wa + 3), ref_rd(wa + 2), ref_rd(wa + 1), ref_rd(wa)};
      end
      e.lat = lat; e.acc = cyc; e.rq = rq;
      ldq.push_back(e);
    end else begin
      w.addr = wa; w.rq = rq;
      if (by) begin
        w.strb = 4'b0001 << a[1:0];
        w.data = {4{wd[7:0]}};
        rmem[a] = wd[7:0];
      end else begin
        w.strb = 4'b1111;
        w.data = wd;
        for (int k = 0; k < 4; k++) rmem[wa + k] = wd[k*8 +: 8];
      end
      wrq.push_back(w);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // backing memory model: ack pulse after LAT cycles of mem_req
  int mcnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mcnt = 0;
    end else if (mem_req && !mem_ack) begin
      if (mcnt == LAT - 1) begin
        mcnt = 0;
        mem_ack <= 1'b1;
        if (mem_store) begin
          wr_t w;
          logic [31:0] m;
          if (wrq.size() == 0) begin
            check(1'b0, "R5", "unexpected write", mem_addr, 32'h0);
          end else begin
            w = wrq.pop_front();
            m = {{8{w.strb[3]}}, {8{w.strb[2]}}, {8{w.strb[1]}}, {8{w.strb[0]}}};
            check(mem_addr == w.addr, w.rq, "write address", mem_addr, w.addr);
            check(mem_wstrb == w.strb, w.rq, "write strobes", 32'(mem_wstrb), 32'(w.strb));
            check((mem_wdata & m) == (w.data & m), w.rq, "write data", mem_wdata & m, w.data & m);
          end
          for (int k = 0; k < 4; k++)
            if (mem_wstrb[k]) bmem[mem_addr + k] = mem_wdata[k*8 +: 8];
        end else begin
          logic [127:0] line;
          check(mem_addr[3:0] == 4'h0, "R3", "fill address aligned", mem_addr, {mem_addr[31:4], 4'h0});
          for (int k = 0; k < 16; k++) line[k*8 +: 8] = mem_rd(mem_addr + k);
          mem_rdata <= line;
        end
      end else begin
        mcnt++;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // monitor
  always @(negedge clk) begin : mon
    ld_t e;
    if (!rst) begin
      if (resp_valid) begin
        if (ldq.size() == 0) begin
          check(1'b0, "R5", "unexpected response", resp_data, 32'h0);
        end else begin
          e = ldq.pop_front();
          check(resp_data == e.data, e.rq, "load data", resp_data, e.data);
          if (e.lat >= 0)
            check((cyc - e.acc) == e.lat, e.rq, "latency", 32'(cyc - e.acc), 32'(e.lat));
        end
      end
      if (mem_req && req_ready) r8_bad++;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
    check(resp_valid == 1'b0, "R1", "no response after reset", 32'(resp_valid), 32'h0);
    check(mem_req == 1'b0, "R1", "memory idle after reset", 32'(mem_req), 32'h0);

    // R1 / R3: cold miss, then hits to the filled line (R2, R4 words)
    issue(0, 0, 32'h0000_0100, 0, MISS_LAT, "R1");
    issue(0, 0, 32'h0000_0104, 0, HIT_LAT, "R2");
    issue(0, 0, 32'h0000_0108, 0, HIT_LAT, "R2");
    issue(0, 0, 32'h0000_010C, 0, HIT_LAT, "R3");
    issue(0, 1, 32'h0000_0101, 0, HIT_LAT, "R4");
    issue(0, 1, 32'h0000_010F, 0, HIT_LAT, "R4");

    // R6: byte and word store hits, neighbours preserved
    issue(1, 1, 32'h0000_010E, 32'h0000_009C, -1, "R6");
    issue(0, 1, 32'h0000_010E, 0, HIT_LAT, "R4");
    issue(0, 0, 32'h0000_010C, 0, HIT_LAT, "R6");
    issue(1, 1, 32'h0000_0101, 32'h0000_0041, -1, "R5");
    issue(0, 0, 32'h0000_0100, 0, HIT_LAT, "R6");
    issue(1, 0, 32'h0000_0104, 32'hDEAD_BEEF, -1, "R5");
    issue(0, 0, 32'h0000_0104, 0, HIT_LAT, "R6");

    // R7: store miss does not allocate
    issue(1, 0, 32'h0000_3040, 32'h1234_5678, -1, "R7");
    issue(0, 0, 32'h0000_3040, 0, MISS_LAT, "R7");
    issue(0, 1, 32'h0000_3043, 0, HIT_LAT, "R4");
    issue(1, 1, 32'h0000_3183, 32'h0000_00F0, -1, "R7");
    issue(0, 1, 32'h0000_3183, 0, MISS_LAT, "R7");

    // R9: fill four ways of one set, all hit; a fifth tag evicts one
    for (int t = 0; t < 4; t++) issue(0, 0, 32'h0000_0500 + 32'(t) * 32'h2000, 0, MISS_LAT, "R9");
    for (int t = 0; t < 4; t++) issue(0, 0, 32'h0000_0504 + 32'(t) * 32'h2000, 0, HIT_LAT, "R9");
    issue(0, 0, 32'h0000_8500, 0, MISS_LAT, "R9");
    issue(0, 1, 32'h0000_8507, 0, HIT_LAT, "R9");
    for (int t = 0; t < 4; t++) issue(0, 0, 32'h0000_0508 + 32'(t) * 32'h2000, 0, -1, "R9");
    issue(0, 0, 32'h0000_850C, 0, -1, "R9");

    // R3: hit load right behind a fill of the same line
    issue(0, 0, 32'h0000_0A00, 0, MISS_LAT, "R3");
    issue(0, 0, 32'h0000_0A0C, 0, HIT_LAT, "R3");

    while (ldq.size() != 0 || wrq.size() != 0 || mem_req) @(negedge clk);
    repeat (3) @(negedge clk);
    check(r8_bad == 0, "R8", "ready high during memory transaction", 32'(r8_bad), 32'h0);
    summary();
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

endmodule